// File: doc/BRIEF.md
# Programmable Interval Timer with Compare

This block is a bus-attached interval timer. An up-counter advances once per fixed 10 µs tick while counting is enabled. A prescaler derives that tick from the system clock. The count is compared with a programmable interval. When the count reaches the interval, the block raises a match flag and restarts the counter from zero. A carry out of the counter sets a sticky overflow flag. Both events drive a level interrupt request, which carries a priority level that software selects.

Software reaches the block through four single-cycle strobes that share one 36-bit write word. A control write changes the priority level and the flags. It can also start or stop counting, single-step a stopped counter, or clear the whole block. A status read returns the control state and the interval. A data write loads the interval, and a data read returns the live count. After each control write, data write or data read, the block compares the count with the interval at once. An interrupt already pending is dropped at the start of every control write and is then evaluated again.

Top module: `ivtimer`

## Requirements
- R1: After reset, the count is 0, the interval is all ones, and the priority level, match flag, overflow flag, run bit and PI bit are all 0. `irq` is low.
- R2: While the run bit is set, the count rises by exactly one every tick period (`CLK_HZ/1e6*TICK_US` clock cycles). While the run bit is clear, the count changes only through a control write.
- R3: When an advance brings the count equal to the interval, the match flag is set, the count returns to 0 and `irq` rises.
- R4: A carry out of the counter sets the overflow flag and wraps the count to 0. The flag stays set until a control write clears it. If the interval is below the count, counting continues up to the wrap.
- R5: Control word bits: 3 clears the match flag, 11 sets it; 4 clears the overflow flag, 12 sets it; 5 sets the run bit, 6 clears it; 7 sets the PI bit, 8 clears it. When a set bit and its clear bit are both present, clear wins.
- R6: Control bit 9 clears the count, both flags, the run bit and the PI bit, and resets the prescaler. The rest of that same word is applied afterwards, so its level field and its set bits take effect.
- R7: Control bit 10 adds one to the count only if the run bit is clear (after any bit 9 clear). The step goes through the same overflow and match checks as a tick, and `irq` rises if either flag is then set.
- R8: A status read returns the level in bits 2:0, the match flag in bit 3, the overflow flag in bit 4, the run bit in bit 5, the PI bit in bit 7 and the interval from bit 18 upward. Every other bit reads as 0.
- R9: A data write loads the low counter-width bits of the word into the interval. A data read returns the count in the low bits. After a control write, data write or data read, a count equal to the interval sets the match flag and raises `irq`.
- R10: A control write first drops `irq`. `irq` is then high only if the run bit and either flag are set, or if a step or compare in that write set a flag. Without a control write, a raised `irq` stays high.
- R11: Each control write loads bits 2:0 as the priority level, and the level is driven on `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ctl | input | 1 | Control write strobe, one cycle |
| rd_stat | input | 1 | Status read strobe |
| wr_data | input | 1 | Interval write strobe |
| rd_data | input | 1 | Count read strobe |
| wdata | input | 36 | Write word for control and interval writes |
| rdata | output | 36 | Read word: status or count, 0 when no read strobe is high |
| irq | output | 1 | Level interrupt request |
| irq_level | output | 3 | Priority level attached to the request |

## Verification
A count that advances on the wrong cycle, or that fails to restart at the interval, shows in the next data read. It also shows in `irq` within one tick period of the expected match. A wrong flag or run bit shows in the following status read. A wrong decision on dropping or raising the request shows on `irq` one cycle after the control write. Overflow is reached with a narrow counter and a fast tick, so wrap-around and the sticky flag appear within a few hundred ticks.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
// ivt_pkg: shared constants and types for the interval timer.
// Assumes a 36-bit processor word; control bit positions are fixed
// because software composes the control word.
package ivt_pkg;

    localparam int BUS_W = 36;

    // Control word field positions
    localparam int C_LVL_LSB   = 0;
    localparam int C_CLR_MATCH = 3;
    localparam int C_CLR_OVF   = 4;
    localparam int C_RUN_ON    = 5;
    localparam int C_RUN_OFF   = 6;
    localparam int C_PI_ON     = 7;
    localparam int C_PI_OFF    = 8;
    localparam int C_GCLR      = 9;
    localparam int C_STEP      = 10;
    localparam int C_SET_MATCH = 11;
    localparam int C_SET_OVF   = 12;
    localparam int C_TOP       = 12;

    // Status word field positions
    localparam int S_LVL_LSB = 0;
    localparam int S_MATCH   = 3;
    localparam int S_OVF     = 4;
    localparam int S_RUN     = 5;
    localparam int S_PI      = 7;
    localparam int S_IVL_LSB = 18;

    // Decoded control word
    typedef struct packed {
        logic [2:0] lvl;
        logic       clr_match;
        logic       clr_ovf;
        logic       run_on;
        logic       run_off;
        logic       pi_on;
        logic       pi_off;
        logic       gclr;
        logic       step;
        logic       set_match;
        logic       set_ovf;
    } ctl_t;

    // Clock cycles per tick for a clock in Hz and a tick in microseconds
    function automatic int tick_div(input int hz, input int us);
        int d;
        d = (hz / 1000000) * us;
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
`timescale 1ns/1ps
// ivt_prescaler: emits a one-cycle tick every DIV cycles while run is high.
// Assumes DIV >= 1; holds its phase while stopped and restarts on clr.
module ivt_prescaler #(
    parameter int DIV = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            // Every cycle is a tick when no division is needed
            assign tick = run;
        end else begin : g_count
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            // Count cycles of the current tick period
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    phase_q <= '0;
                end else if (run) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end

            assign tick = run && (phase_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/ivt_ctl_decode.sv
`timescale 1ns/1ps
// ivt_ctl_decode: splits the low control bits of the write word into fields.
// Purely combinational; upper word bits carry no control meaning.
module ivt_ctl_decode
    import ivt_pkg::*;
(
    input  logic [C_TOP:0] word,
    output ctl_t           ctl
);
    // Map each control bit to its named field
    always_comb begin
        ctl.lvl       = word[C_LVL_LSB +: 3];
        ctl.clr_match = word[C_CLR_MATCH];
        ctl.clr_ovf   = word[C_CLR_OVF];
        ctl.run_on    = word[C_RUN_ON];
        ctl.run_off   = word[C_RUN_OFF];
        ctl.pi_on     = word[C_PI_ON];
        ctl.pi_off    = word[C_PI_OFF];
        ctl.gclr      = word[C_GCLR];
        ctl.step      = word[C_STEP];
        ctl.set_match = word[C_SET_MATCH];
        ctl.set_ovf   = word[C_SET_OVF];
    end

endmodule

// File: rtl/ivt_core.sv
`timescale 1ns/1ps
// ivt_core: counter, interval, flags and interrupt request state.
// Assumes at most one bus strobe per cycle (control > data write > data read).
// A tick in the same cycle as a bus operation is applied first.
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_ctl,
    input  ctl_t             ctl,
    input  logic             wr_data,
    input  logic [CNT_W-1:0] load_val,
    input  logic             rd_data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ivl,
    output logic [2:0]       lvl,
    output logic             match,
    output logic             ovf,
    output logic             run,
    output logic             pi,
    output logic             irq,
    output logic             psc_clr
);
    logic [CNT_W-1:0] cnt_q, ivl_q, n_cnt, n_ivl;
    logic [2:0]       lvl_q, n_lvl;
    logic             match_q, ovf_q, run_q, pi_q, irq_q;
    logic             n_match, n_ovf, n_run, n_pi, n_irq;
    logic             eq_chk;
    logic [CNT_W+1:0] adv;

    // Advance by one: returns {match hit, carry, new count}
    function automatic logic [CNT_W+1:0] advance(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] lim);
        logic [CNT_W:0]   s;
        logic [CNT_W-1:0] nc;
        logic             hit;
        s   = {1'b0, c} + (CNT_W+1)'(1);
        nc  = s[CNT_W-1:0];
        hit = (nc == lim);
        if (hit) nc = '0;
        return {hit, s[CNT_W], nc};
    endfunction

    // Next-state computation: tick, then the bus operation, then compare
    always_comb begin
        n_cnt   = cnt_q;
        n_ivl   = ivl_q;
        n_lvl   = lvl_q;
        n_match = match_q;
        n_ovf   = ovf_q;
        n_run   = run_q;
        n_pi    = pi_q;
        n_irq   = irq_q;
        eq_chk  = 1'b0;
        adv     = '0;

        if (tick && run_q) begin
            adv   = advance(n_cnt, n_ivl);
            n_cnt = adv[CNT_W-1:0];
            if (adv[CNT_W])   n_ovf   = 1'b1;
            if (adv[CNT_W+1]) n_match = 1'b1;
            if (adv[CNT_W] || adv[CNT_W+1]) n_irq = 1'b1;
        end

        if (wr_ctl) begin
            n_irq = 1'b0;
            if (ctl.gclr) begin
                n_cnt   = '0;
                n_match = 1'b0;
                n_ovf   = 1'b0;
                n_run   = 1'b0;
                n_pi    = 1'b0;
            end
            n_lvl = ctl.lvl;
            if (ctl.step && !n_run) begin
                adv   = advance(n_cnt, n_ivl);
                n_cnt = adv[CNT_W-1:0];
                if (adv[CNT_W])   n_ovf   = 1'b1;
                if (adv[CNT_W+1]) n_match = 1'b1;
                if (n_match || n_ovf) n_irq = 1'b1;
            end
            if (ctl.run_on)    n_run   = 1'b1;
            if (ctl.run_off)   n_run   = 1'b0;
            if (ctl.set_ovf)   n_ovf   = 1'b1;
            if (ctl.clr_ovf)   n_ovf   = 1'b0;
            if (ctl.set_match) n_match = 1'b1;
            if (ctl.clr_match) n_match = 1'b0;
            if (ctl.pi_on)     n_pi    = 1'b1;
            if (ctl.pi_off)    n_pi    = 1'b0;
            if (n_run && (n_match || n_ovf)) n_irq = 1'b1;
            eq_chk = 1'b1;
        end else if (wr_data) begin
            n_ivl  = load_val;
            eq_chk = 1'b1;
        end else if (rd_data) begin
            eq_chk = 1'b1;
        end

        if (eq_chk && (n_cnt == n_ivl)) begin
            n_match = 1'b1;
            n_irq   = 1'b1;
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ivl_q   <= '1;
            lvl_q   <= '0;
            match_q <= 1'b0;
            ovf_q   <= 1'b0;
            run_q   <= 1'b0;
            pi_q    <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            cnt_q   <= n_cnt;
            ivl_q   <= n_ivl;
            lvl_q   <= n_lvl;
            match_q <= n_match;
            ovf_q   <= n_ovf;
            run_q   <= n_run;
            pi_q    <= n_pi;
            irq_q   <= n_irq;
        end
    end

    assign cnt     = cnt_q;
    assign ivl     = ivl_q;
    assign lvl     = lvl_q;
    assign match   = match_q;
    assign ovf     = ovf_q;
    assign run     = run_q;
    assign pi      = pi_q;
    assign irq     = irq_q;
    assign psc_clr = wr_ctl && ctl.gclr;

endmodule

// File: rtl/ivtimer.sv
`timescale 1ns/1ps
// ivtimer: top of the interval timer. Wires prescaler, decoder and core,
// and forms the read word. Assumes CNT_W <= 18 so the interval fits the
// status word, and single-cycle strobes from the bus side.
module ivtimer
    import ivt_pkg::*;
#(
    parameter int CLK_HZ  = 50000000,
    parameter int TICK_US = 10,
    parameter int CNT_W   = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             rd_stat,
    input  logic             wr_data,
    input  logic             rd_data,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq,
    output logic [2:0]       irq_level
);
    localparam int DIV = tick_div(CLK_HZ, TICK_US);

    ctl_t             ctl_w;
    logic             tick_w, psc_clr_w;
    logic [CNT_W-1:0] cnt_w, ivl_w;
    logic [2:0]       lvl_w;
    logic             match_w, ovf_w, run_w, pi_w;
    logic             unused_hi;

    assign unused_hi = ^wdata[BUS_W-1:CNT_W];

    ivt_prescaler #(.DIV(DIV)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .clr   (psc_clr_w),
        .tick  (tick_w)
    );

    ivt_ctl_decode u_dec (
        .word (wdata[C_TOP:0]),
        .ctl  (ctl_w)
    );

    ivt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .wr_ctl   (wr_ctl),
        .ctl      (ctl_w),
        .wr_data  (wr_data),
        .load_val (wdata[CNT_W-1:0]),
        .rd_data  (rd_data),
        .cnt      (cnt_w),
        .ivl      (ivl_w),
        .lvl      (lvl_w),
        .match    (match_w),
        .ovf      (ovf_w),
        .run      (run_w),
        .pi       (pi_w),
        .irq      (irq),
        .psc_clr  (psc_clr_w)
    );

    // Read word: status layout on a status read, count on a data read
    always_comb begin
        rdata = '0;
        if (rd_stat) begin
            rdata[S_LVL_LSB +: 3]     = lvl_w;
            rdata[S_MATCH]            = match_w;
            rdata[S_OVF]              = ovf_w;
            rdata[S_RUN]              = run_w;
            rdata[S_PI]               = pi_w;
            rdata[S_IVL_LSB +: CNT_W] = ivl_w;
        end else if (rd_data) begin
            rdata[CNT_W-1:0] = cnt_w;
        end
    end

    assign irq_level = lvl_w;

endmodule

// File: rtl/ivtimer_chk.sv
`timescale 1ns/1ps
// ivtimer_chk: temporal properties of the interval timer, bound to ivtimer.
module ivtimer_chk #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ctl,
    input logic             wr_data,
    input logic [35:0]      wdata,
    input logic             irq,
    input logic [2:0]       irq_level,
    input logic             tick_w,
    input logic             run_w,
    input logic             ovf_w,
    input logic [CNT_W-1:0] cnt_w,
    input logic [CNT_W-1:0] ivl_w
);
    // R2: a stopped counter changes only through a control write
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !wr_ctl) |=> $stable(cnt_w));

    // R3: after a plain tick the count never rests on a nonzero interval
    p_match_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_w && run_w && !wr_ctl && !wr_data && ivl_w != '0) |=> (cnt_w != ivl_w));

    // R4: overflow flag is sticky unless a control write clears it
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_w && !(wr_ctl && (wdata[4] || wdata[9]))) |=> ovf_w);

    // R6: general clear without a run-on bit leaves the counter stopped
    p_gclr_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[9] && !wdata[5]) |=> !run_w);

    // R7: a step request has no effect while running
    p_step_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[10] && !wdata[9] && run_w && !tick_w) |=> (cnt_w == $past(cnt_w)));

    // R10: a raised request holds until a control write
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ctl) |=> irq);

    // R11: the level field of each control write reaches irq_level
    p_level_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (irq_level == $past(wdata[2:0])));

endmodule

bind ivtimer ivtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (wr_ctl),
    .wr_data   (wr_data),
    .wdata     (wdata),
    .irq       (irq),
    .irq_level (irq_level),
    .tick_w    (tick_w),
    .run_w     (run_w),
    .ovf_w     (ovf_w),
    .cnt_w     (cnt_w),
    .ivl_w     (ivl_w)
);

// File: tb/sim_ivtimer.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers queue expected read/irq values; the monitor
// compares them at the falling edge of the cycle the strobe is active.
// Runs with an 8-bit counter and a 50-cycle tick to reach overflow quickly.
module sim_ivtimer;
    localparam int K_STAT = 0;
    localparam int K_DATA = 1;
    localparam int K_IRQ  = 2;

    typedef struct {
        int          kind;
        logic [35:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_ctl = 1'b0, rd_stat = 1'b0, wr_data = 1'b0, rd_data = 1'b0;
    logic        chk_irq = 1'b0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        irq;
    logic [2:0]  irq_level;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;

    always #10 clk = ~clk;

    ivtimer #(.CLK_HZ(5000000), .TICK_US(10), .CNT_W(8)) u0 (
        .clk (clk), .rst_n (rst_n), .wr_ctl (wr_ctl), .rd_stat (rd_stat),
        .wr_data (wr_data), .rd_data (rd_data), .wdata (wdata),
        .rdata (rdata), .irq (irq), .irq_level (irq_level)
    );

    // Monitor: pop and compare one expected item per sampled strobe
    always @(negedge clk) begin
        if (rd_stat || rd_data || chk_irq) begin
            item_t       it;
            logic [35:0] act;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: result with no expected item");
            end else begin
                it  = q.pop_front();
                act = (it.kind == K_IRQ) ? {32'b0, irq_level, irq} : rdata;
                n_chk++;
                if (act !== it.exp)
                    begin
                        n_bad++;
                        $display("FAIL %s: kind=%0d actual=%h expected=%h",
                                 it.tag, it.kind, act, it.exp);
                    end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic ctl_wr(input logic [35:0] w);
        @(posedge clk); #1;
        wdata = w; wr_ctl = 1'b1;
        @(posedge clk); #1;
        wr_ctl = 1'b0;
    endtask

    task automatic ivl_wr(input logic [35:0] w);
        @(posedge clk); #1;
        wdata = w; wr_data = 1'b1;
        @(posedge clk); #1;
        wr_data = 1'b0;
    endtask

    task automatic stat_rd(input logic [35:0] e, input string tag);
        @(posedge clk); #1;
        q.push_back('{K_STAT, e, tag});
        rd_stat = 1'b1;
        @(posedge clk); #1;
        rd_stat = 1'b0;
    endtask

    task automatic cnt_rd(input logic [35:0] e, input string tag);
        @(posedge clk); #1;
        q.push_back('{K_DATA, e, tag});
        rd_data = 1'b1;
        @(posedge clk); #1;
        rd_data = 1'b0;
    endtask

    // Expected value is {irq_level, irq}
    task automatic irq_chk(input logic [35:0] e, input string tag);
        @(posedge clk); #1;
        q.push_back('{K_IRQ, e, tag});
        chk_irq = 1'b1;
        @(posedge clk); #1;
        chk_irq = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        idle(3); #1; rst_n = 1'b1;

        // R1: reset state, interval all ones (8-bit)
        stat_rd(36'h3FC0000, "R1");
        irq_chk(36'h0, "R1");
        cnt_rd(36'h0, "R1");

        // R5/R10/R11: set both flags while stopped, no request
        ctl_wr(36'h1803);
        irq_chk(36'h6, "R10");
        // R10: enabling with flags set raises the request at level 3
        ctl_wr(36'h23);
        irq_chk(36'h7, "R10");
        stat_rd(36'h3FC003B, "R8");
        // R5: clear flags and stop; R10 request dropped
        ctl_wr(36'h58);
        irq_chk(36'h0, "R10");
        stat_rd(36'h3FC0000, "R5");
        // R5: clear wins over set, PI bit set and clear
        ctl_wr(36'h808);
        stat_rd(36'h3FC0000, "R5");
        ctl_wr(36'h80);
        stat_rd(36'h3FC0080, "R5");
        ctl_wr(36'h180);
        stat_rd(36'h3FC0000, "R5");

        // R6: general clear with a level in the same word
        ctl_wr(36'h206);
        stat_rd(36'h3FC0006, "R6");
        cnt_rd(36'h0, "R6");

        // R9: data write loads the interval
        ivl_wr(36'h5);
        stat_rd(36'h0140006, "R9");
        ctl_wr(36'h200);

        // R7: single steps while stopped, match on the fifth
        for (int i = 0; i < 4; i++) ctl_wr(36'h400);
        cnt_rd(36'h4, "R7");
        ctl_wr(36'h400);
        cnt_rd(36'h0, "R7");
        stat_rd(36'h0140008, "R7");
        irq_chk(36'h1, "R7");

        // R2/R3: run from 0 toward interval 5, tick every 50 cycles
        ctl_wr(36'h28);
        idle(123);
        cnt_rd(36'h2, "R2");
        idle(150);
        irq_chk(36'h1, "R3");
        cnt_rd(36'h0, "R3");
        // R7: step is ignored while running
        ctl_wr(36'h420);
        cnt_rd(36'h0, "R7");
        ctl_wr(36'h48);
        ctl_wr(36'h200);

        // R9: data write equal to the count raises match and request
        for (int i = 0; i < 3; i++) ctl_wr(36'h400);
        ivl_wr(36'h3);
        irq_chk(36'h1, "R9");
        cnt_rd(36'h3, "R9");

        // R4: interval below count, run on to the wrap
        ctl_wr(36'h200);
        ctl_wr(36'h400);
        ctl_wr(36'h400);
        ivl_wr(36'h1);
        ctl_wr(36'h22);
        irq_chk(36'h4, "R10");
        idle(12721);
        stat_rd(36'h0040032, "R4");
        irq_chk(36'h5, "R4");
        cnt_rd(36'h0, "R4");
        ctl_wr(36'h50);
        irq_chk(36'h0, "R10");

        // R6: set bits in a general-clear word still apply
        ctl_wr(36'h225);
        stat_rd(36'h0040025, "R6");
        ctl_wr(36'h200);

        idle(2);
        finish_run();
    end

endmodule